// File: doc/BRIEF.md
# Constant-Time Binary Modular Inverter

This block returns the multiplicative inverse of an operand `a` modulo an odd prime `p`, both `N` bits wide. It runs a binary extended Euclidean iteration on a pair of values and a pair of coefficients. Each clock cycle it works out every possible update of that state and picks one with multiplexers. Halving an odd coefficient modulo `p` uses a stored `p >> 1` plus a carry-in, not a data-dependent path. Subtraction results are brought back into `[0, p)` by a conditional add of `p`.

The iteration always runs the worst-case count of `4N` steps, whatever the operands. One more cycle then resolves the result. The number of cycles and the order of operations are therefore the same for every input pair. When either value first reaches 1, the matching coefficient is captured. Later steps keep running on the registers but cannot disturb that captured answer. A caller pulses `start_i` with the operands. It then waits for the one-cycle `done_o` pulse and reads `res_o`, which holds until the next completion.

Top module: `modinv_ct`

## Requirements
- R1: After reset, `done_o` is 0 and `res_o` is 0.
- R2: For an odd prime `p` (at least 3) and any `a` in `[1, p-1]` presented with `start_i`, the returned `res_o` satisfies `(a * res_o) mod p == 1`.
- R3: `done_o` rises exactly `4N+1` clock cycles after the edge at which an idle block samples `start_i` high, for every operand pair.
- R4: `done_o` is high for exactly one cycle per operation. `res_o` changes only together with a `done_o` pulse and holds its value in between.
- R5: While an operation is in progress, `start_i` pulses and changes on `a_i` or `p_i` are ignored. The running operation keeps its latency and result.
- R6: The edge operands give their known inverses: `a = 1` returns 1, `a = p-1` returns `p-1`, and the smallest modulus `p = 3` works.
- R7: The returned value lies in `[1, p-1]`. The two internal coefficients stay in `[0, p)` on every iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an inversion; sampled only while idle |
| a_i | input | N | Operand to invert, in `[1, p-1]` |
| p_i | input | N | Odd prime modulus |
| res_o | output | N | Inverse of the operand, registered |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `N = 16`. This allows full-width primes such as 65521 and 65519, where the coefficient halving and the `p` fix-up after subtraction touch the top bit, together with tiny moduli such as 3 and 5, where the values reach 1 within the first few iterations and most of the fixed run happens after the answer is already captured. A 16-bit width also keeps the bench's reference inverse, a modular exponentiation, inside 64-bit arithmetic, so random operands can be checked against an independent computation.

// File: rtl/ctinv_pkg.sv
package ctinv_pkg;

  // Branch taken by one iteration; all four are computed every cycle.
  typedef enum logic [1:0] {
    BR_HALVE_U = 2'd0,
    BR_HALVE_V = 2'd1,
    BR_SUB_U   = 2'd2,
    BR_SUB_V   = 2'd3
  } branch_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

  // Bit positions inside the one-hot comparator result.
  localparam int REL_GT = 0;
  localparam int REL_LT = 1;
  localparam int REL_EQ = 2;

endpackage

// File: rtl/ctinv_cmp.sv
module ctinv_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [2:0]   rel
);
  import ctinv_pkg::*;

  always_comb begin
    rel         = '0;
    rel[REL_GT] = (lhs > rhs);
    rel[REL_LT] = (lhs < rhs);
    rel[REL_EQ] = (lhs == rhs);
  end

endmodule

// File: rtl/ctinv_halve.sv
module ctinv_halve #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] phalf,
  output logic [W-1:0] y
);
  // (x + p) / 2 for odd x equals (x >> 1) + (p >> 1) + 1; both terms are
  // always added, the odd bit masks them, so the path is data independent.
  logic [W-1:0] mask_add;
  logic [W-1:0] carry_in;

  assign mask_add = phalf & {W{x[0]}};
  assign carry_in = {{(W-1){1'b0}}, x[0]};
  assign y        = (x >> 1) + mask_add + carry_in;

endmodule

// File: rtl/ctinv_modsub.sv
module ctinv_modsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] minu,
  input  logic [W-1:0] subt,
  input  logic [W-1:0] pmod,
  output logic [W-1:0] diff
);
  logic [W:0]   raw;
  logic         borrow;
  logic [W-1:0] fix;

  assign raw    = {1'b0, minu} - {1'b0, subt};
  assign borrow = raw[W];
  assign fix    = pmod & {W{borrow}};
  assign diff   = raw[W-1:0] + fix;

endmodule

// File: rtl/ctinv_ctrl.sv
module ctinv_ctrl #(
  parameter int STEPS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last
);
  import ctinv_pkg::*;

  localparam int CW = $clog2(STEPS + 1);

  state_e        state_q;
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(STEPS));
  assign load   = (state_q == ST_IDLE) && start;
  assign step   = (state_q == ST_RUN);
  assign last   = step && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (at_end) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ctinv_core.sv
module ctinv_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] p_in,
  output logic         u_one,
  output logic         v_one,
  output logic [W-1:0] coef1,
  output logic [W-1:0] coef2,
  output logic [W-1:0] pmod
);
  import ctinv_pkg::*;

  logic [W-1:0] u_q, v_q, p_q, ph_q;
  logic [W-1:0] x_q  [2];
  logic [W-1:0] x_hv [2];
  logic [W-1:0] x_sb [2];
  logic [W-1:0] x_n  [2];
  logic [W-1:0] u_n, v_n;
  logic [W-1:0] u_half, v_half, u_less_v, v_less_u;
  logic [2:0]   rel;
  logic         sel1, sel2;
  branch_e      br;

  ctinv_cmp #(.W(W)) i_cmp (
    .lhs (u_q),
    .rhs (v_q),
    .rel (rel)
  );

  // Coefficient lanes: lane 0 is x1 (paired with u), lane 1 is x2 (with v).
  for (genvar g = 0; g < 2; g++) begin : g_lane
    ctinv_halve #(.W(W)) i_halve (
      .x     (x_q[g]),
      .phalf (ph_q),
      .y     (x_hv[g])
    );
    ctinv_modsub #(.W(W)) i_sub (
      .minu (x_q[g]),
      .subt (x_q[1-g]),
      .pmod (p_q),
      .diff (x_sb[g])
    );
  end

  assign u_half   = u_q >> 1;
  assign v_half   = v_q >> 1;
  assign u_less_v = u_q - v_q;
  assign v_less_u = v_q - u_q;

  assign sel1 = ~u_q[0];
  assign sel2 = ~v_q[0];

  always_comb begin
    if (sel1)      br = BR_HALVE_U;
    else if (sel2) br = BR_HALVE_V;
    else begin
      case (rel)
        3'b001:  br = BR_SUB_U;
        3'b100:  br = BR_SUB_U;
        default: br = BR_SUB_V;
      endcase
    end
  end

  always_comb begin
    u_n    = u_q;
    v_n    = v_q;
    x_n[0] = x_q[0];
    x_n[1] = x_q[1];
    case (br)
      BR_HALVE_U: begin u_n = u_half;   x_n[0] = x_hv[0]; end
      BR_HALVE_V: begin v_n = v_half;   x_n[1] = x_hv[1]; end
      BR_SUB_U:   begin u_n = u_less_v; x_n[0] = x_sb[0]; end
      default:    begin v_n = v_less_u; x_n[1] = x_sb[1]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u_q    <= '0;
      v_q    <= '0;
      p_q    <= '0;
      ph_q   <= '0;
      x_q[0] <= '0;
      x_q[1] <= '0;
    end else if (load) begin
      u_q    <= a_in;
      v_q    <= p_in;
      p_q    <= p_in;
      ph_q   <= {1'b0, p_in[W-1:1]};
      x_q[0] <= W'(1);
      x_q[1] <= '0;
    end else if (step) begin
      u_q    <= u_n;
      v_q    <= v_n;
      x_q[0] <= x_n[0];
      x_q[1] <= x_n[1];
    end
  end

  assign u_one = (u_q == W'(1));
  assign v_one = (v_q == W'(1));
  assign coef1 = x_q[0];
  assign coef2 = x_q[1];
  assign pmod  = p_q;

endmodule

// File: rtl/modinv_ct.sv
module modinv_ct #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] p_i,
  output logic [N-1:0] res_o,
  output logic         done_o
);
  localparam int STEPS = 4 * N;

  logic         load_w, step_w, last_w;
  logic         u_one_w, v_one_w;
  logic [N-1:0] x1_w, x2_w, p_w;
  logic         found_q;
  logic [N-1:0] hold_q, cand_w, final_w;
  logic         hit_w;

  ctinv_ctrl #(.STEPS(STEPS)) i_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .load  (load_w),
    .step  (step_w),
    .last  (last_w)
  );

  ctinv_core #(.W(N)) i_core (
    .clk   (clk),
    .rst   (rst),
    .load  (load_w),
    .step  (step_w),
    .a_in  (a_i),
    .p_in  (p_i),
    .u_one (u_one_w),
    .v_one (v_one_w),
    .coef1 (x1_w),
    .coef2 (x2_w),
    .pmod  (p_w)
  );

  assign hit_w   = !found_q && (u_one_w || v_one_w);
  assign cand_w  = u_one_w ? x1_w : x2_w;
  assign final_w = found_q ? hold_q : cand_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      found_q <= 1'b0;
      hold_q  <= '0;
      res_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_w) begin
        found_q <= 1'b0;
      end else if (step_w) begin
        if (hit_w) begin
          found_q <= 1'b1;
          hold_q  <= cand_w;
        end
        if (last_w) begin
          res_o  <= final_w;
          done_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/modinv_ct_chk.sv
module modinv_ct_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic         run,
  input logic [N-1:0] a_i,
  input logic [N-1:0] p_i,
  input logic [N-1:0] x1,
  input logic [N-1:0] x2,
  input logic [N-1:0] pmod,
  input logic [N-1:0] res_o,
  input logic         done_o
);
  localparam int LAT = 4 * N + 1;

  logic [N-1:0]   a_cap, p_cap;
  logic [15:0]    lat_q;
  logic [2*N-1:0] prod;
  logic [2*N-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap <= '0;
      p_cap <= '0;
      lat_q <= '0;
    end else if (load) begin
      a_cap <= a_i;
      p_cap <= p_i;
      lat_q <= '0;
    end else if (lat_q != 16'hffff) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  assign prod = {{N{1'b0}}, a_cap} * {{N{1'b0}}, res_o};
  assign rem  = (p_cap == '0) ? '0 : prod % {{N{1'b0}}, p_cap};

  p_result_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> rem == (2*N)'(1));

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> lat_q == 16'(LAT));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_res_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> (done_o || $stable(res_o)));

  p_coef_range_r7: assert property (@(posedge clk) disable iff (rst)
    run |-> (x1 < pmod) && (x2 < pmod));

  p_res_range_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (res_o != '0) && (res_o < p_cap));

endmodule

bind modinv_ct modinv_ct_chk #(.N(N)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .load   (load_w),
  .run    (step_w),
  .a_i    (a_i),
  .p_i    (p_i),
  .x1     (x1_w),
  .x2     (x2_w),
  .pmod   (p_w),
  .res_o  (res_o),
  .done_o (done_o)
);

// File: tb/test_modinv_ct.sv
module test_modinv_ct;
  localparam int N          = 16;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4 * N + 1;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [N-1:0] a_i, p_i;
  logic [N-1:0] res_o;
  logic         done_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  modinv_ct #(.N(N)) i_modinv_ct (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .a_i     (a_i),
    .p_i     (p_i),
    .res_o   (res_o),
    .done_o  (done_o)
  );

  function automatic longint modpow(longint b, longint e, longint m);
    longint r = 1;
    b = b % m;
    while (e > 0) begin
      if (e[0]) r = (r * b) % m;
      b = (b * b) % m;
      e = e >> 1;
    end
    return r;
  endfunction

  function automatic longint ref_inv(longint a, longint p);
    return modpow(a, p - 2, p);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Runs one inversion; optionally disturbs inputs mid-run (R5).
  task automatic run_one(longint a, longint p, bit disturb,
                         output longint res, output int cyc);
    @(negedge clk);
    a_i     = a[N-1:0];
    p_i     = p[N-1:0];
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 1000) begin
      if (disturb && cyc == 3) begin
        start_i = 1'b1;
        a_i     = ~a_i;
        p_i     = 16'h0007;
      end
      if (disturb && cyc == 5) start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 1000) check(1'b0, "R3", "watchdog in run", cyc, LAT);
    res = longint'(res_o);
  endtask

  task automatic full_check(longint a, longint p, bit disturb, string req);
    longint res;
    int     cyc;
    longint exp;
    exp = ref_inv(a, p);
    run_one(a, p, disturb, res, cyc);
    check(res == exp, req, "inverse", res, exp);
    check(((a * res) % p) == 1, "R2", "a*res mod p", (a * res) % p, 1);
    check(res >= 1 && res < p, "R7", "result range", res, exp);
    check(cyc == LAT, "R3", "latency", cyc, LAT);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R3", "global watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    longint primes [8] = '{3, 5, 7, 257, 32749, 40961, 65519, 65521};
    longint res0;
    int     cyc0;
    void'($urandom(32'd1234));
    rst     = 1'b1;
    start_i = 1'b0;
    a_i     = '0;
    p_i     = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    check(res_o == '0, "R1", "res after reset", res_o, 0);

    // R6: edge operands
    full_check(1, 3, 1'b0, "R6");
    full_check(2, 3, 1'b0, "R6");
    full_check(1, 65521, 1'b0, "R6");
    full_check(65520, 65521, 1'b0, "R6");
    full_check(2, 65519, 1'b0, "R6");
    full_check(32768, 65521, 1'b0, "R6");

    // R4: single-cycle pulse and held result
    run_one(12345, 65521, 1'b0, res0, cyc0);
    @(negedge clk);
    check(done_o == 1'b0, "R4", "done width", done_o, 0);
    repeat (4) @(negedge clk);
    check(longint'(res_o) == res0, "R4", "result held", res_o, res0);
    check(done_o == 1'b0, "R4", "no spurious done", done_o, 0);

    // R5: start and operand changes during a run ignored
    full_check(777, 40961, 1'b1, "R5");
    full_check(3, 5, 1'b1, "R5");

    // R2: random operands over several primes
    for (int i = 0; i < 160; i++) begin
      longint p;
      longint a;
      p = primes[$urandom_range(0, 7)];
      a = 1 + longint'($urandom_range(0, 32'(p - 2)));
      full_check(a, p, (i % 17) == 0, "R2");
    end

    summary();
    $finish;
  end

endmodule